// File: doc/BRIEF.md
# Memory Command Sequence Executor

This block plays back a list of 32-bit words that the host has stored in a small sequence memory. The host loads the memory through a simple write port. It then pulses `start` together with a start address. From that address the block fetches one word per sequencer cycle and turns each word into pin-level DDR3 command signals (row strobe, column strobe and write enable, all active low), plus an address, a bank and ten control lanes. The control lanes are on-die termination, clock enable, chip select, DQ output enable, DQS output enable, DQS toggle, termination enable, buffer write strobe, buffer read strobe and buffer page reset.

A word whose 3-bit operation code is non-zero is a command word. It places that command on the pins for one cycle. It can optionally request one idle command cycle after it, so that back-to-back bursts run at two cycles each. A word whose code is zero is a skip word. It idles the command pins for a programmable number of cycles while its own control lanes stay in force. A skip word with its done flag set ends the run. The sequencer runs at half the memory clock, so each count unit stands for two memory clocks.

Top module: `memseq_exec`

## Requirements
- R1: A word with code bits [31:29] non-zero is a command. In the cycle it is in force, {ras_n,cas_n,we_n} equal the bitwise inverse of the code (for example, code 4 gives 011 and code 2 gives 101). `mem_addr` equals bits [28:14] and `mem_bank` equals bits [13:11].
- R2: In every cycle a word is in force, the lane outputs follow bits [9:0] of the word: bit0 odt, bit1 cke, bit2 chip_sel, bit3 dq_oe, bit4 dqs_oe, bit5 dqs_flip, bit6 term_en, bit7 bufw_stb, bit8 bufr_stb, bit9 buf_page_rst.
- R3: When a command word has bit [10] set, it is followed by exactly one extra cycle. In that cycle the command pins read 111, and the address, bank and lanes hold the command's values. The next word is fetched only after that cycle.
- R4: A skip word (code 0) without the done flag holds the command pins at 111, `mem_addr` at 0, `mem_bank` at bits [13:11] and the lanes at bits [9:0]. It does so for N+1 cycles, where N is the count in bits [27:18]. A count of 0 still takes one cycle.
- R5: A skip word with bit [28] set is in force for exactly one cycle, whatever its count. In that cycle `seq_done` is high, `busy` is low, the command pins read 111 and the word's bank and lanes are driven.
- R6: `start` sampled high while the block is idle loads `start_addr`. In the cycle after that edge, `busy` is high and the outputs are still idle. The first word is in force in the cycle after that.
- R7: Each finished word advances the fetch address by one. The address wraps from DEPTH-1 to 0.
- R8: `start` sampled high while `busy` is high has no effect on the running sequence.
- R9: After reset, and in every cycle after a run ends, the block is idle: `busy` and `seq_done` are low, the command pins read 111, and the address, bank and lanes are 0.
- R10: A host write with `wr_en` high stores `wr_data` at `wr_addr`. Any later run that fetches that address uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (half the memory clock rate) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe into the sequence memory |
| wr_addr | input | AW | Host write address |
| wr_data | input | 32 | Host write word |
| start | input | 1 | Run request, taken only while idle |
| start_addr | input | AW | Address of the first word of the run |
| busy | output | 1 | High while a run is in progress |
| seq_done | output | 1 | One-cycle completion flag |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mem_addr | output | 15 | Memory address pins |
| mem_bank | output | 3 | Memory bank pins |
| odt | output | 1 | On-die termination lane |
| cke | output | 1 | Clock enable lane |
| chip_sel | output | 1 | Select lane |
| dq_oe | output | 1 | DQ output enable lane |
| dqs_oe | output | 1 | DQS output enable lane |
| dqs_flip | output | 1 | DQS toggle lane |
| term_en | output | 1 | Termination enable lane |
| bufw_stb | output | 1 | Buffer write strobe lane |
| bufr_stb | output | 1 | Buffer read strobe lane |
| buf_page_rst | output | 1 | Buffer page reset lane |

## Verification
A directed activate, read and precharge program is compared cycle by cycle against a trace that the bench derives from the word fields. This shows that commands, the post-command idle slot, skip lengths and the done cycle each land in the right cycle. A program placed across the top of the memory tells correct address wrap apart from an overflow into a wrong word. Random programs with random codes, lanes, skip counts and idle-slot flags separate a correct decode of each field from a swapped or misplaced bit. Some of these runs carry a second start pulse in mid-run, which shows whether `start` is properly ignored while busy. Rewriting a stored word and running again shows that host writes reach later fetches.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

    localparam int WORD_W = 32;
    localparam int MADDR_W = 15;
    localparam int BANK_W = 3;
    localparam int CODE_W = 3;
    localparam int CNT_W = 10;
    localparam int LANE_N = 10;

    // field positions inside a stored word
    localparam int CODE_LSB = 29;
    localparam int MADDR_LSB = 14;
    localparam int BANK_LSB = 11;
    localparam int GAP_BIT = 10;
    localparam int DONE_BIT = 28;
    localparam int CNT_LSB = 18;

    typedef struct packed {
        logic page_rst;
        logic buf_rd;
        logic buf_wr;
        logic term;
        logic dqs_flip;
        logic dqs_oe;
        logic dq_oe;
        logic sel;
        logic cke;
        logic odt;
    } lanes_t;

    typedef enum logic [CODE_W-1:0] {
        OP_SKIP = 3'd0,
        OP_ZQ   = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_ACT  = 3'd4,
        OP_PRE  = 3'd5,
        OP_REF  = 3'd6,
        OP_MRS  = 3'd7
    } op_e;

    typedef struct packed {
        logic                is_cmd;
        op_e                 op;
        logic [MADDR_W-1:0]  addr;
        logic [BANK_W-1:0]   bank;
        logic                gap;
        logic                done;
        logic [CNT_W-1:0]    cnt;
        lanes_t              lanes;
    } word_t;

    typedef struct packed {
        logic [2:0]          pins_n;
        logic [MADDR_W-1:0]  addr;
        logic [BANK_W-1:0]   bank;
        lanes_t              lanes;
    } pinout_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_GAP  = 2'd2,
        S_WAIT = 2'd3
    } st_e;

    localparam logic [2:0] PINS_NOP = 3'b111;
    localparam pinout_t PIN_IDLE = '{pins_n: PINS_NOP, addr: '0, bank: '0, lanes: '0};

    function automatic word_t unpack_word(input logic [WORD_W-1:0] w);
        word_t d;
        d.op     = op_e'(w[CODE_LSB +: CODE_W]);
        d.is_cmd = (d.op != OP_SKIP);
        d.addr   = w[MADDR_LSB +: MADDR_W];
        d.bank   = w[BANK_LSB +: BANK_W];
        d.gap    = w[GAP_BIT];
        d.done   = w[DONE_BIT];
        d.cnt    = w[CNT_LSB +: CNT_W];
        d.lanes  = lanes_t'(w[LANE_N-1:0]);
        return d;
    endfunction

    function automatic pinout_t drive_word(input word_t d);
        pinout_t p;
        p.lanes = d.lanes;
        p.bank  = d.bank;
        if (d.is_cmd) begin
            p.pins_n = ~d.op;
            p.addr   = d.addr;
        end else begin
            p.pins_n = PINS_NOP;
            p.addr   = '0;
        end
        return p;
    endfunction

endpackage

// File: rtl/memseq_store.sv
module memseq_store #(
    parameter int DEPTH = 64,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [memseq_pkg::WORD_W-1:0] wr_data,
    input  logic [AW-1:0]                 rd_addr,
    output logic [memseq_pkg::WORD_W-1:0] rd_data
);
    import memseq_pkg::*;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // combinational read: the fetched word is usable in the same cycle
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/memseq_decode.sv
module memseq_decode (
    input  logic [memseq_pkg::WORD_W-1:0] word_in,
    output memseq_pkg::word_t             dec,
    output memseq_pkg::pinout_t           pins
);
    import memseq_pkg::*;

    always_comb begin
        dec  = unpack_word(word_in);
        pins = drive_word(dec);
    end

endmodule

// File: rtl/memseq_ctrl.sv
module memseq_ctrl #(
    parameter int AW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [AW-1:0]       start_addr,
    input  memseq_pkg::word_t   dec,
    input  memseq_pkg::pinout_t word_pins,
    output logic [AW-1:0]       pc,
    output logic                busy,
    output logic                done,
    output memseq_pkg::pinout_t pout
);
    import memseq_pkg::*;

    st_e              state;
    logic [CNT_W-1:0] cnt;
    logic [AW-1:0]    pc_q;
    logic             busy_q;
    logic             done_q;
    pinout_t          pout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            pc_q   <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            pout_q <= PIN_IDLE;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    pout_q <= PIN_IDLE;
                    if (start) begin
                        pc_q   <= start_addr;
                        busy_q <= 1'b1;
                        state  <= S_RUN;
                    end
                end
                S_RUN: begin
                    pout_q <= word_pins;
                    if (dec.is_cmd) begin
                        if (dec.gap) begin
                            state <= S_GAP;
                        end else begin
                            pc_q <= pc_q + 1'b1;
                        end
                    end else if (dec.done) begin
                        done_q <= 1'b1;
                        busy_q <= 1'b0;
                        state  <= S_IDLE;
                    end else if (dec.cnt == '0) begin
                        pc_q <= pc_q + 1'b1;
                    end else begin
                        cnt   <= dec.cnt;
                        state <= S_WAIT;
                    end
                end
                S_GAP: begin
                    pout_q.pins_n <= PINS_NOP;
                    pc_q          <= pc_q + 1'b1;
                    state         <= S_RUN;
                end
                S_WAIT: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                        pc_q  <= pc_q + 1'b1;
                        state <= S_RUN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign pc   = pc_q;
    assign busy = busy_q;
    assign done = done_q;
    assign pout = pout_q;

    // R9: outside a run and its done cycle the pins stay idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !done_q) |-> (pout_q == PIN_IDLE));

    // R5: the done cycle shows no command and busy already low
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && pout_q.pins_n == PINS_NOP));

    // R5: busy only ends through a done word
    p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> done_q);

    // R3: the slot after a flagged command is a NOP with lanes held
    p_gap_nop_r3: assert property (@(posedge clk) disable iff (rst)
        (state == S_GAP) |=> (pout_q.pins_n == PINS_NOP && $stable(pout_q.lanes)
                              && $stable(pout_q.addr)));

    // R4: all outputs hold while a skip count runs down
    p_skip_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |=> $stable(pout_q));

    // R8: a start pulse during a run does not move the fetch address
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && start) |=> $stable(pc_q) || (state == S_RUN));

endmodule

// File: rtl/memseq_exec.sv
module memseq_exec #(
    parameter int DEPTH = 64,
    parameter int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic          seq_done,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic [14:0]   mem_addr,
    output logic [2:0]    mem_bank,
    output logic          odt,
    output logic          cke,
    output logic          chip_sel,
    output logic          dq_oe,
    output logic          dqs_oe,
    output logic          dqs_flip,
    output logic          term_en,
    output logic          bufw_stb,
    output logic          bufr_stb,
    output logic          buf_page_rst
);
    import memseq_pkg::*;

    logic [AW-1:0]     pc;
    logic [WORD_W-1:0] word;
    word_t             dec;
    pinout_t           word_pins;
    pinout_t           pout;

    memseq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (pc),
        .rd_data (word)
    );

    memseq_decode decode_i (
        .word_in (word),
        .dec     (dec),
        .pins    (word_pins)
    );

    memseq_ctrl #(.AW(AW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .dec        (dec),
        .word_pins  (word_pins),
        .pc         (pc),
        .busy       (busy),
        .done       (seq_done),
        .pout       (pout)
    );

    assign {ras_n, cas_n, we_n} = pout.pins_n;
    assign mem_addr     = pout.addr;
    assign mem_bank     = pout.bank;
    assign odt          = pout.lanes.odt;
    assign cke          = pout.lanes.cke;
    assign chip_sel     = pout.lanes.sel;
    assign dq_oe        = pout.lanes.dq_oe;
    assign dqs_oe       = pout.lanes.dqs_oe;
    assign dqs_flip     = pout.lanes.dqs_flip;
    assign term_en      = pout.lanes.term;
    assign bufw_stb     = pout.lanes.buf_wr;
    assign bufr_stb     = pout.lanes.buf_rd;
    assign buf_page_rst = pout.lanes.page_rst;

endmodule

// File: tb/memseq_exec_tb.sv
`timescale 1ns/1ps
module memseq_exec_tb_top;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic busy, seq_done, ras_n, cas_n, we_n;
    logic [14:0] mem_addr;
    logic [2:0] mem_bank;
    logic odt, cke, chip_sel, dq_oe, dqs_oe, dqs_flip, term_en, bufw_stb, bufr_stb, buf_page_rst;
    logic [9:0] lanes_now;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] img [DEPTH];

    always #2 clk = ~clk;

    memseq_exec #(.DEPTH(DEPTH), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .start_addr(start_addr), .busy(busy), .seq_done(seq_done),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mem_addr(mem_addr), .mem_bank(mem_bank),
        .odt(odt), .cke(cke), .chip_sel(chip_sel), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .dqs_flip(dqs_flip), .term_en(term_en), .bufw_stb(bufw_stb), .bufr_stb(bufr_stb),
        .buf_page_rst(buf_page_rst)
    );

    assign lanes_now = {buf_page_rst, bufr_stb, bufw_stb, term_en, dqs_flip,
                        dqs_oe, dq_oe, chip_sel, cke, odt};

    function automatic logic [31:0] mk_cmd(input logic [2:0] code, input logic [14:0] a,
                                           input logic [2:0] b, input logic gap, input logic [9:0] l);
        return {code, a, b, gap, l};
    endfunction

    function automatic logic [31:0] mk_skip(input logic done, input logic [9:0] n,
                                            input logic [2:0] b, input logic [9:0] l);
        return {3'b000, done, n, 4'b0000, b, 1'b0, l};
    endfunction

    task automatic chk(input string req, input logic eb, input logic ed, input logic [2:0] ec,
                       input logic [14:0] ea, input logic [2:0] ebk, input logic [9:0] el);
        logic [32:0] act, exp;
        act = {busy, seq_done, ras_n, cas_n, we_n, mem_addr, mem_bank, lanes_now};
        exp = {eb, ed, ec, ea, ebk, el};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [31:0] w);
        wr_en = 1'b1; wr_addr = a; wr_data = w;
        img[a] = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        start = 1'b0;
    endtask

    // runs one sequence and compares every cycle with the trace derived from img
    task automatic run_prog(input logic [AW-1:0] sa, input bit poke);
        logic [AW-1:0] pc;
        logic [31:0] w;
        int guard;
        start_addr = sa;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6 start latency", 1'b1, 1'b0, 3'b111, 15'd0, 3'd0, 10'd0);
        @(negedge clk);
        if (poke) begin
            start = 1'b1;            // R8: sampled while busy
            start_addr = sa + 6'd5;
        end
        pc = sa;
        guard = 0;
        while (guard < 400) begin
            guard++;
            w = img[pc];
            if (w[31:29] != 3'b000) begin
                chk("R1 R2 command", 1'b1, 1'b0, ~w[31:29], w[28:14], w[13:11], w[9:0]);
                step();
                if (w[10]) begin
                    chk("R3 gap", 1'b1, 1'b0, 3'b111, w[28:14], w[13:11], w[9:0]);
                    step();
                end
                pc = pc + 1'b1;      // R7 wraps naturally
            end else if (w[28]) begin
                chk("R5 done", 1'b0, 1'b1, 3'b111, 15'd0, w[13:11], w[9:0]);
                step();
                chk("R9 idle after run", 1'b0, 1'b0, 3'b111, 15'd0, 3'd0, 10'd0);
                break;
            end else begin
                for (int k = 0; k <= int'(w[27:18]); k++) begin
                    chk("R4 skip", 1'b1, 1'b0, 3'b111, 15'd0, w[13:11], w[9:0]);
                    step();
                end
                pc = pc + 1'b1;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        int len;
        logic [2:0] code;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < DEPTH; i++) img[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset", 1'b0, 1'b0, 3'b111, 15'd0, 3'd0, 10'd0);

        // directed activate / read / precharge program
        put(6'd0, mk_cmd(3'd4, 15'h1234, 3'd5, 1'b0, 10'h002));
        put(6'd1, mk_skip(1'b0, 10'd1, 3'd5, 10'h002));
        put(6'd2, mk_cmd(3'd2, 15'h0040, 3'd5, 1'b1, 10'h10E));
        put(6'd3, mk_skip(1'b0, 10'd2, 3'd5, 10'h04C));
        put(6'd4, mk_cmd(3'd5, 15'h0400, 3'd5, 1'b0, 10'h202));
        put(6'd5, mk_skip(1'b0, 10'd0, 3'd0, 10'h002));
        put(6'd6, mk_skip(1'b1, 10'd9, 3'd2, 10'h081));
        run_prog(6'd0, 1'b0);

        // R10: replace the read with back-to-back gapped writes, rerun
        put(6'd2, mk_cmd(3'd3, 15'h0048, 3'd1, 1'b1, 10'h03B));
        put(6'd3, mk_cmd(3'd3, 15'h0050, 3'd1, 1'b1, 10'h03B));
        run_prog(6'd0, 1'b1);

        // R7: program straddling the top of memory
        put(6'd62, mk_cmd(3'd6, 15'h0000, 3'd0, 1'b0, 10'h002));
        put(6'd63, mk_skip(1'b0, 10'd3, 3'd7, 10'h3FF));
        put(6'd0, mk_cmd(3'd7, 15'h7ABC, 3'd3, 1'b1, 10'h155));
        put(6'd1, mk_skip(1'b1, 10'd0, 3'd4, 10'h2AA));
        run_prog(6'd62, 1'b0);

        // random programs
        for (int p = 0; p < 24; p++) begin
            base = 6'($urandom_range(0, DEPTH - 1));
            len = $urandom_range(1, 8);
            for (int j = 0; j < len; j++) begin
                code = 3'($urandom_range(0, 7));
                if (code != 3'd0)
                    put(base + 6'(j), mk_cmd(code, 15'($urandom), 3'($urandom), 1'($urandom), 10'($urandom)));
                else
                    put(base + 6'(j), mk_skip(1'b0, 10'($urandom_range(0, 5)), 3'($urandom), 10'($urandom)));
            end
            put(base + 6'(len), mk_skip(1'b1, 10'($urandom_range(0, 20)), 3'($urandom), 10'($urandom)));
            run_prog(base, (p % 3) == 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule